// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

The engine walks a circular ring of transmit descriptors in memory and streams the frame buffer each one points at, byte by byte, toward a MAC. Software writes the ring's location, the number of slots and a producer index through a small word-addressed register port. The engine keeps its own consumer index and owns every slot from that index up to, but not including, the producer index. For each slot it reads the buffer pointer, the length and flags, and the destination port. It sends the bytes, optionally marks the slot as done in memory, and then moves to the next slot.

The memory side is a simple single-outstanding master: a held request, and a one-cycle acknowledge that carries read data. The outbound stream is a valid/ready byte channel. Each byte carries an end-of-frame marker and a three-bit port number. Clearing the enable bit lets the slot in flight finish cleanly before the engine goes idle.

Top module: `txring_dma`

## Requirements
- R1: After reset every register reads zero, the busy flag is 0, and neither `mem_req` nor `tx_valid` is asserted.
- R2: Register byte offsets: 0x00 ring base address; 0x04 slot count; 0x08 producer index; 0x0C consumer index, read-only, with writes ignored; 0x10 control, where bit 0 is run enable, bit 1 is busy (read-only) and bit 6 is done write-back enable; 0x14 index reset, where bit 0 is the command. Accesses whose low two address bits are not zero are ignored and read zero.
- R3: A new slot is started only when run enable is 1, the slot count is non-zero and the consumer index differs from the producer index. Otherwise the engine stays idle and issues no memory request.
- R4: Slot i occupies 16 bytes at base + 16*i. Word 0 is the buffer address. Word 1 holds the length in bits 29:16 and the last-segment flag in bit 30. Word 3 holds the port number in bits 26:24. A memory request holds its address, direction and write data stable until the one-cycle `mem_ack`, and read data is valid with that acknowledge.
- R5: Bytes leave in increasing address order. The byte at address A comes from bits 8*(A mod 4)+7 : 8*(A mod 4) of the word at A rounded down to a multiple of 4, and any buffer alignment is allowed. While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_port` hold.
- R6: `tx_last` is high only on the final byte of a slot whose last-segment flag is 1. A slot with length 0 sends no byte but is still completed.
- R7: With write-back enabled, the engine rewrites word 1 of the finished slot with bit 31 set and every other bit unchanged. With write-back disabled, the slot is not written.
- R8: After each slot the consumer index becomes index+1, or 0 when index+1 is not below the slot count.
- R9: Clearing run enable while busy lets the current slot finish, including its write-back. Busy stays 1 until then, after which it falls and no further slot is started.
- R10: An index-reset command sets the consumer index to 0 when the engine is idle. It is ignored while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_port | output | 3 | Destination port number of the current frame |

## Verification
The bench builds the engine with a four-bit ring index and programs slot counts of 4 and later 5, so the consumer index wraps many times in a short run. Its memory model answers after a random latency of zero to two cycles. Together with a randomly stalling sink and random buffer offsets, this exercises every byte lane, word refetches in the middle of a frame, and held stream beats. Directed cases cover a zero-length slot, a non-final segment, write-back switched off, disabling mid-frame and an index reset issued both while busy and while idle.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;

  // register word selects (byte offset / 4)
  localparam logic [3:0] REG_BASE = 4'd0;
  localparam logic [3:0] REG_CNT  = 4'd1;
  localparam logic [3:0] REG_PROD = 4'd2;
  localparam logic [3:0] REG_CONS = 4'd3;
  localparam logic [3:0] REG_CTRL = 4'd4;
  localparam logic [3:0] REG_IRST = 4'd5;

  // control register bits
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_BUSY = 1;
  localparam int CTRL_WB   = 6;
  localparam int IRST_CMD  = 0;

  // descriptor layout
  localparam int          LEN_W       = 14;
  localparam int          FLG_DONE    = 31;
  localparam int          FLG_LAST    = 30;
  localparam int          LEN_LO      = 16;
  localparam int          LEN_HI      = LEN_LO + LEN_W - 1;
  localparam int          PORT_LO     = 24;
  localparam int          PORT_HI     = 26;
  localparam logic [31:0] OFS_BUFPTR  = 32'd0;
  localparam logic [31:0] OFS_CTLWORD = 32'd4;
  localparam logic [31:0] OFS_PORTW   = 32'd12;

  typedef enum logic [2:0] {
    S_IDLE, S_PTR, S_CTL, S_PRT, S_WORD, S_EMIT, S_WBK, S_DONE
  } eng_state_t;

  function automatic logic [31:0] ring_next(input logic [31:0] idx, input logic [31:0] cnt);
    return ((idx + 32'd1) >= cnt) ? 32'd0 : idx + 32'd1;
  endfunction

  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 4);
  endfunction

  function automatic logic [31:0] word_base(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] mark_done(input logic [31:0] w);
    return w | (32'd1 << FLG_DONE);
  endfunction

endpackage

// File: rtl/txr_regs.sv
`timescale 1ns/1ps
module txr_regs import txr_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [5:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             eng_busy,
  input  logic             eng_retire,
  output logic [31:0]      ring_base,
  output logic [IDX_W:0]   ring_cnt,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic             run_en,
  output logic             wb_en
);

  logic       aligned;
  logic [3:0] wsel;
  logic       wr_base, wr_cnt, wr_prod, wr_ctrl, wr_irst;
  logic       idx_clear;

  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign wsel      = reg_addr[5:2];
  assign wr_base   = reg_wr && aligned && (wsel == REG_BASE);
  assign wr_cnt    = reg_wr && aligned && (wsel == REG_CNT);
  assign wr_prod   = reg_wr && aligned && (wsel == REG_PROD);
  assign wr_ctrl   = reg_wr && aligned && (wsel == REG_CTRL);
  assign wr_irst   = reg_wr && aligned && (wsel == REG_IRST);
  assign idx_clear = wr_irst && reg_wdata[IRST_CMD] && !eng_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      ring_cnt  <= '0;
      prod_idx  <= '0;
      cons_idx  <= '0;
      run_en    <= 1'b0;
      wb_en     <= 1'b0;
    end else begin
      if (wr_base) ring_base <= reg_wdata;
      if (wr_cnt)  ring_cnt  <= reg_wdata[IDX_W:0];
      if (wr_prod) prod_idx  <= reg_wdata[IDX_W-1:0];
      if (wr_ctrl) begin
        run_en <= reg_wdata[CTRL_RUN];
        wb_en  <= reg_wdata[CTRL_WB];
      end
      if (eng_retire)
        cons_idx <= IDX_W'(ring_next(32'(cons_idx), 32'(ring_cnt)));
      else if (idx_clear)
        cons_idx <= '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (wsel)
        REG_BASE: reg_rdata = ring_base;
        REG_CNT:  reg_rdata = 32'(ring_cnt);
        REG_PROD: reg_rdata = 32'(prod_idx);
        REG_CONS: reg_rdata = 32'(cons_idx);
        REG_CTRL: begin
          reg_rdata[CTRL_RUN]  = run_en;
          reg_rdata[CTRL_BUSY] = eng_busy;
          reg_rdata[CTRL_WB]   = wb_en;
        end
        default:  reg_rdata = '0;
      endcase
    end
  end

  // consumer index is frozen while a slot is in flight
  AST_IDX_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_retire) |=> (cons_idx == $past(cons_idx))); // R10

endmodule

// File: rtl/txr_engine.sv
`timescale 1ns/1ps
module txr_engine import txr_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             wb_en,
  input  logic [31:0]      ring_base,
  input  logic [IDX_W:0]   ring_cnt,
  input  logic [IDX_W-1:0] prod_idx,
  input  logic [IDX_W-1:0] cons_idx,
  output logic             busy,
  output logic             retire,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [2:0]       tx_port
);

  eng_state_t       st;
  logic [31:0]      slot_a;
  logic [31:0]      buf_a;
  logic [31:0]      ctl_q;
  logic [31:0]      word_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [2:0]       port_q;

  // named internal events
  logic [31:0] byte_a;
  logic        final_byte;
  logic        word_end;
  logic        start_ok;
  eng_state_t  after_frame;

  assign byte_a      = buf_a + 32'(cnt_q);
  assign final_byte  = (cnt_q == (len_q - 14'd1));
  assign word_end    = (byte_a[1:0] == 2'b11);
  assign start_ok    = (st == S_IDLE) && run_en && (ring_cnt != '0) && (cons_idx != prod_idx);
  assign after_frame = wb_en ? S_WBK : S_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      slot_a <= '0;
      buf_a  <= '0;
      ctl_q  <= '0;
      word_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      port_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_ok) begin
          slot_a <= slot_addr(ring_base, 32'(cons_idx));
          st     <= S_PTR;
        end
        S_PTR: if (mem_ack) begin
          buf_a <= mem_rdata;
          st    <= S_CTL;
        end
        S_CTL: if (mem_ack) begin
          ctl_q <= mem_rdata;
          len_q <= mem_rdata[LEN_HI:LEN_LO];
          st    <= S_PRT;
        end
        S_PRT: if (mem_ack) begin
          port_q <= mem_rdata[PORT_HI:PORT_LO];
          cnt_q  <= '0;
          st     <= (len_q == '0) ? after_frame : S_WORD;
        end
        S_WORD: if (mem_ack) begin
          word_q <= mem_rdata;
          st     <= S_EMIT;
        end
        S_EMIT: if (tx_ready) begin
          cnt_q <= cnt_q + 14'd1;
          if (final_byte)    st <= after_frame;
          else if (word_end) st <= S_WORD;
        end
        S_WBK:  if (mem_ack) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_PTR:        mem_addr = slot_a + OFS_BUFPTR;
      S_CTL, S_WBK: mem_addr = slot_a + OFS_CTLWORD;
      S_PRT:        mem_addr = slot_a + OFS_PORTW;
      S_WORD:       mem_addr = word_base(byte_a);
      default:      mem_addr = '0;
    endcase
  end

  assign mem_req   = st inside {S_PTR, S_CTL, S_PRT, S_WORD, S_WBK};
  assign mem_we    = (st == S_WBK);
  assign mem_wdata = mark_done(ctl_q);
  assign tx_valid  = (st == S_EMIT);
  assign tx_data   = pick_byte(word_q, byte_a[1:0]);
  assign tx_last   = tx_valid && ctl_q[FLG_LAST] && final_byte;
  assign tx_port   = port_q;
  assign busy      = (st != S_IDLE);
  assign retire    = (st == S_DONE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_port))); // R5

  AST_STAY_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !run_en) |=> !busy); // R9

  AST_STAY_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cons_idx == prod_idx)) |=> !busy); // R3

endmodule

// File: rtl/txring_dma.sv
`timescale 1ns/1ps
module txring_dma #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic [2:0]  tx_port
);

  logic [31:0]      ring_base;
  logic [IDX_W:0]   ring_cnt;
  logic [IDX_W-1:0] prod_idx;
  logic [IDX_W-1:0] cons_idx;
  logic             run_en;
  logic             wb_en;
  logic             eng_busy;
  logic             eng_retire;

  txr_regs #(.IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_busy   (eng_busy),
    .eng_retire (eng_retire),
    .ring_base  (ring_base),
    .ring_cnt   (ring_cnt),
    .prod_idx   (prod_idx),
    .cons_idx   (cons_idx),
    .run_en     (run_en),
    .wb_en      (wb_en)
  );

  txr_engine #(.IDX_W(IDX_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .wb_en     (wb_en),
    .ring_base (ring_base),
    .ring_cnt  (ring_cnt),
    .prod_idx  (prod_idx),
    .cons_idx  (cons_idx),
    .busy      (eng_busy),
    .retire    (eng_retire),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_port   (tx_port)
  );

  // a write only ever targets a slot control word
  AST_WRITE_IS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[3:0] == (ring_base[3:0] + 4'd4))); // R7

endmodule

// File: tb/txring_dma_tb.sv
`timescale 1ns/1ps
module txring_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic [2:0]  tx_port;

  int n_chk = 0;
  int n_fail = 0;
  bit hold_ready = 0;
  bit rand_ready = 0;
  int lat = 0;
  int sw_idx = 0;
  int ring_cnt = 4;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_ctl [0:15];
  logic [11:0] exp_q [$];

  txring_dma #(.IDX_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_port(tx_port)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model: random latency, one-cycle acknowledge
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        lat <= int'($urandom % 3);
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // sink ready driver
  initial forever begin
    @(posedge clk);
    #1;
    if (hold_ready)      tx_ready = 1'b0;
    else if (rand_ready) tx_ready = (($urandom % 4) != 0);
    else                 tx_ready = 1'b1;
  end

  // stream monitor: R4 R5 R6
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0)
        check(0, "R6", "byte with no frame pending", {20'd0, tx_port, tx_last, tx_data}, 32'd0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        check({tx_port, tx_last, tx_data} == e, "R5", "stream beat {port,last,data}",
              {20'd0, tx_port, tx_last, tx_data}, {20'd0, e});
      end
    end
  end

  function automatic int nxt(input int i);
    return ((i + 1) >= ring_cnt) ? 0 : i + 1;
  endfunction

  task automatic set_byte(input logic [31:0] a, input logic [7:0] v);
    mem[a[11:2]][{a[1:0], 3'b000} +: 8] = v;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic submit(input int len, input int off, input int port, input bit lseg);
    logic [31:0] b, d, w;
    logic [7:0]  v;
    b = 32'h400 + 32'(sw_idx) * 128 + 32'(off);
    d = 32'h100 + 32'(sw_idx) * 16;
    for (int i = 0; i < len; i++) begin
      v = 8'($urandom);
      set_byte(b + 32'(i), v);
      exp_q.push_back({3'(port), (lseg && (i == len - 1)), v});
    end
    w = {1'b0, lseg, 14'(len), 16'($urandom)};
    mem[d[11:2]]     = b;
    mem[d[11:2] + 1] = w;
    mem[d[11:2] + 2] = $urandom;
    mem[d[11:2] + 3] = ($urandom & ~32'h0700_0000) | (32'(port) << 24);
    exp_ctl[sw_idx] = w;
    sw_idx = nxt(sw_idx);
    reg_write(6'h08, 32'(sw_idx));
  endtask

  task automatic check_wb(input int slot, input bit on, input string tag);
    logic [31:0] got, exp;
    got = mem[10'(((32'h100 + 32'(slot) * 16) >> 2) + 1)];
    exp = on ? (exp_ctl[slot] | 32'h8000_0000) : exp_ctl[slot];
    check(got == exp, tag, "slot control word after completion", got, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] di, c;
    bit ok;
    ok = 0;
    for (int k = 0; k < 4000; k++) begin
      reg_read(6'h0C, di);
      reg_read(6'h10, c);
      if (di == 32'(sw_idx) && !c[1]) begin ok = 1; break; end
    end
    if (!ok) check(0, "R8", "engine did not drain to producer index", di, 32'(sw_idx));
  endtask

  task automatic wait_beat();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (tx_valid) break;
    end
  endtask

  initial begin
    logic [31:0] r, di0;
    bit saw_req;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(6'h00, r); check(r == 0, "R1", "base after reset", r, 0);
    reg_read(6'h04, r); check(r == 0, "R1", "count after reset", r, 0);
    reg_read(6'h08, r); check(r == 0, "R1", "producer after reset", r, 0);
    reg_read(6'h0C, r); check(r == 0, "R1", "consumer after reset", r, 0);
    reg_read(6'h10, r); check(r == 0, "R1", "control after reset", r, 0);
    check(!mem_req && !tx_valid, "R1", "req/valid after reset", {30'd0, mem_req, tx_valid}, 0);

    // R2 register map
    reg_write(6'h00, 32'h100);
    reg_write(6'h04, 32'd4);
    reg_write(6'h0C, 32'd7);
    reg_write(6'h09, 32'd3);
    reg_read(6'h00, r); check(r == 32'h100, "R2", "base readback", r, 32'h100);
    reg_read(6'h04, r); check(r == 32'd4, "R2", "count readback", r, 4);
    reg_read(6'h0C, r); check(r == 0, "R2", "consumer write ignored", r, 0);
    reg_read(6'h08, r); check(r == 0, "R2", "misaligned write ignored", r, 0);
    reg_write(6'h10, 32'h41);
    reg_read(6'h10, r); check(r == 32'h41, "R2", "control readback", r, 32'h41);

    // R3 no work while producer equals consumer
    saw_req = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (mem_req) saw_req = 1; end
    check(!saw_req, "R3", "request with empty ring", {31'd0, saw_req}, 0);

    // directed: unaligned 5-byte frame, port 3
    submit(5, 3, 3, 1);
    wait_idle();
    reg_read(6'h0C, r); check(r == 1, "R8", "consumer after one slot", r, 1);
    check_wb(0, 1, "R7");

    // zero length slot
    submit(0, 0, 2, 1);
    wait_idle();
    check_wb(1, 1, "R6");

    // non-final segment: no tx_last
    submit(6, 1, 5, 0);
    wait_idle();
    check_wb(2, 1, "R6");

    // wrap at count 4
    submit(4, 0, 7, 1);
    wait_idle();
    reg_read(6'h0C, r); check(r == 0, "R8", "consumer wraps to zero", r, 0);

    // write-back disabled
    reg_write(6'h10, 32'h01);
    submit(7, 2, 1, 1);
    wait_idle();
    check_wb(0, 0, "R7");
    reg_write(6'h10, 32'h41);

    // R10 index reset while busy is ignored
    hold_ready = 1;
    submit(6, 0, 4, 1);
    wait_beat();
    reg_write(6'h14, 32'h1);
    hold_ready = 0;
    wait_idle();
    reg_read(6'h0C, r); check(r == 32'(sw_idx), "R10", "reset ignored while busy", r, 32'(sw_idx));
    // R10 index reset while idle
    reg_write(6'h10, 32'h40);
    reg_write(6'h14, 32'h1);
    reg_read(6'h0C, r); check(r == 0, "R10", "reset while idle", r, 0);
    reg_write(6'h08, 32'd0);
    sw_idx = 0;
    reg_write(6'h10, 32'h41);

    // R9 disable while a frame is in flight
    di0 = 32'(sw_idx);
    hold_ready = 1;
    submit(8, 1, 2, 1);
    submit(8, 2, 6, 1);
    wait_beat();
    reg_write(6'h10, 32'h40);
    reg_read(6'h10, r); check(r[1] == 1'b1, "R9", "busy held after disable", r, 32'h42);
    hold_ready = 0;
    for (int k = 0; k < 2000; k++) begin reg_read(6'h10, r); if (!r[1]) break; end
    check(r[1] == 1'b0, "R9", "busy falls after frame", r, 32'h40);
    reg_read(6'h0C, r); check(r == 32'(nxt(int'(di0))), "R9", "one slot retired", r, 32'(nxt(int'(di0))));
    check(exp_q.size() == 8, "R9", "second frame held back", exp_q.size(), 8);
    check_wb(int'(di0), 1, "R9");
    repeat (30) @(negedge clk);
    reg_read(6'h0C, r); check(r == 32'(nxt(int'(di0))), "R3", "no start while disabled", r, 32'(nxt(int'(di0))));
    reg_write(6'h10, 32'h41);
    wait_idle();
    check_wb(nxt(int'(di0)), 1, "R7");

    // random phase with count 5
    reg_write(6'h04, 32'd5);
    ring_cnt = 5;
    rand_ready = 1;
    for (int it = 0; it < 14; it++) begin
      int n, first, slot;
      n = 1 + int'($urandom % 3);
      first = sw_idx;
      for (int j = 0; j < n; j++)
        submit(int'($urandom % 41), int'($urandom % 4), int'($urandom % 8), 1'($urandom % 2));
      wait_idle();
      slot = first;
      for (int j = 0; j < n; j++) begin
        check_wb(slot, 1, "R7");
        slot = nxt(slot);
      end
    end
    rand_ready = 0;
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all expected bytes sent", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog expired: actual=hung expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule